// File: doc/BRIEF.md
# Frame Buffer Rectangle Fill Engine

This block accepts a three-word fill packet from the rendering command stream. It then paints one solid colour into a rectangle of a halfword-addressed frame buffer. The first word carries the opcode and a 24-bit colour. The second word carries the top-left corner and the third word carries the rectangle size. After the third word the engine narrows the colour to a 15-bit halfword. It snaps the left edge down to a 16-halfword granule and widens the span up to whole granules. It then issues one memory write per cycle, sweeping each row from left to right and the rows from top to bottom.

The frame buffer is 1024 halfwords wide and 512 rows tall, and coordinates wrap at both edges. The fill has no notion of the mask bit: every halfword in the rectangle is overwritten, and bit 15 is always cleared. While a fill is in progress the command input is held off. A single-cycle done pulse marks the end of each packet.

Top module: `vram_fill_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_we` are low and `cmd_ready` is high.
- R2: A word is taken when `cmd_valid` and `cmd_ready` are both high. The first word of a packet has opcode 02h in bits 31:24. The second word has X in bits 15:0 and Y in bits 31:16. The third word has width in bits 15:0 and height in bits 31:16, both counted in halfwords and rows.
- R3: A first word whose bits 31:24 are not 02h is taken and dropped without any write. The next word is then treated as a new first word.
- R4: Every written halfword equals {0, colour[23:19], colour[15:11], colour[7:3]}. Red comes from bits 7:0 of the first word, green from 15:8 and blue from 23:16.
- R5: Bit 15 of `mem_wdata` is zero on every write.
- R6: The X start is the X field with its low 4 bits cleared, so every row begins on a multiple of 16.
- R7: A non-zero width is rounded up to the next multiple of 16 halfwords, and that many halfwords are written per row.
- R8: A width or height of zero gives no write. `done` then pulses in the cycle after the third word is taken, and `busy` stays low.
- R9: `mem_addr` is {Y[8:0], X[9:0]}. Writes run left to right within a row, then move down one row, starting again at the aligned X start.
- R10: X wraps modulo 1024 and Y wraps modulo 512.
- R11: A write completes in each cycle where `mem_we` and `mem_ready` are both high. While `mem_ready` is low, `mem_we`, `mem_addr` and `mem_wdata` hold.
- R12: `busy` is high from the cycle after the third word until the last write completes, and `cmd_ready` is low while `busy` is high. `done` is high for exactly one cycle, the cycle after the last write, with no write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Engine can take a command word |
| mem_addr | output | 19 | Write address {row, column} |
| mem_wdata | output | 16 | Halfword to write |
| mem_we | output | 1 | Write request |
| mem_ready | input | 1 | Memory takes the write this cycle |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
The assertions assume `mem_ready` is a clean level in every cycle and may drop at any point in a sweep. They also assume packets arrive only through the handshake, so no word lands while a fill is running. The stimulus holds each command word and `cmd_valid` steady until the word is taken. It drives `mem_ready` either always high or from a pseudo-random bit stream, so stalls fall on row ends, wrap points and the last write of a packet.

// File: rtl/fill_pkg.sv
package fill_pkg;

    localparam logic [7:0] FILL_OPCODE = 8'h02;
    localparam int         CMD_W       = 32;
    localparam int         FIELD_W     = 16;
    localparam int         PIX_W       = 16;
    localparam int         CH_IN_W     = 8;
    localparam int         CH_OUT_W    = 5;
    localparam int         N_CH        = 3;

    typedef enum logic [1:0] {
        CAP_HEAD   = 2'd0,
        CAP_CORNER = 2'd1,
        CAP_SIZE   = 2'd2
    } cap_state_e;

    // Place the packed channel fields in a halfword, top bit cleared.
    function automatic logic [PIX_W-1:0] to_halfword(input logic [N_CH*CH_OUT_W-1:0] chans);
        return {{(PIX_W - N_CH*CH_OUT_W){1'b0}}, chans};
    endfunction

endpackage

// File: rtl/fill_pkt_capture.sv
module fill_pkt_capture
    import fill_pkg::*;
#(
    parameter int X_BITS    = 10,
    parameter int Y_BITS    = 9,
    parameter int GRAN_LOG2 = 4,
    localparam int XG_BITS  = X_BITS - GRAN_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [CMD_W-1:0]     cmd_data,
    input  logic                 engine_busy,
    output logic                 cmd_ready,
    output logic                 launch,
    output logic [PIX_W-1:0]     color_o,
    output logic [XG_BITS-1:0]   x_gran_o,
    output logic [Y_BITS-1:0]    y_o,
    output logic [FIELD_W-1:0]   width_o,
    output logic [FIELD_W-1:0]   height_o
);

    typedef struct packed {
        cap_state_e           st;
        logic [PIX_W-1:0]     color;
        logic [XG_BITS-1:0]   xg;
        logic [Y_BITS-1:0]    y;
    } cap_t;

    cap_t cap_d, cap_q;

    logic                        accept;
    logic [N_CH*CH_OUT_W-1:0]    chan_msbs;

    // Keep the top bits of each 8-bit channel, red lowest.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        assign chan_msbs[ch*CH_OUT_W +: CH_OUT_W] =
            cmd_data[ch*CH_IN_W + CH_IN_W - 1 -: CH_OUT_W];
    end

    assign cmd_ready = !engine_busy;
    assign accept    = cmd_valid && cmd_ready;
    assign launch    = accept && (cap_q.st == CAP_SIZE);

    always_comb begin
        cap_d = cap_q;
        unique case (cap_q.st)
            CAP_HEAD: begin
                if (accept && cmd_data[CMD_W-1 -: 8] == FILL_OPCODE) begin
                    cap_d.color = to_halfword(chan_msbs);
                    cap_d.st    = CAP_CORNER;
                end
            end
            CAP_CORNER: begin
                if (accept) begin
                    cap_d.xg = cmd_data[X_BITS-1:GRAN_LOG2];
                    cap_d.y  = cmd_data[FIELD_W +: Y_BITS];
                    cap_d.st = CAP_SIZE;
                end
            end
            CAP_SIZE: begin
                if (accept) begin
                    cap_d.st = CAP_HEAD;
                end
            end
            default: cap_d.st = CAP_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '{st: CAP_HEAD, default: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign color_o  = cap_q.color;
    assign x_gran_o = cap_q.xg;
    assign y_o      = cap_q.y;
    assign width_o  = cmd_data[FIELD_W-1:0];
    assign height_o = cmd_data[CMD_W-1:FIELD_W];

    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !engine_busy) else $error("launch while busy"); // R12

endmodule

// File: rtl/fill_addr_walker.sv
module fill_addr_walker
    import fill_pkg::*;
#(
    parameter int X_BITS    = 10,
    parameter int Y_BITS    = 9,
    parameter int GRAN_LOG2 = 4,
    localparam int XG_BITS  = X_BITS - GRAN_LOG2,
    localparam int GRAN     = 1 << GRAN_LOG2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch,
    input  logic [PIX_W-1:0]           color,
    input  logic [XG_BITS-1:0]         x_gran,
    input  logic [Y_BITS-1:0]          y_start,
    input  logic [FIELD_W-1:0]         width,
    input  logic [FIELD_W-1:0]         height,
    input  logic                       mem_ready,
    output logic [X_BITS+Y_BITS-1:0]   mem_addr,
    output logic [PIX_W-1:0]           mem_wdata,
    output logic                       mem_we,
    output logic                       busy,
    output logic                       done
);

    typedef struct packed {
        logic                 active;
        logic                 done;
        logic [PIX_W-1:0]     color;
        logic [X_BITS-1:0]    x_base;
        logic [X_BITS-1:0]    x;
        logic [Y_BITS-1:0]    y;
        logic [FIELD_W-1:0]   col;
        logic [FIELD_W-1:0]   last_col;
        logic [FIELD_W-1:0]   row;
        logic [FIELD_W-1:0]   last_row;
    } walk_t;

    walk_t wk_d, wk_q;

    logic [FIELD_W-1:0] last_col_w;
    logic [X_BITS-1:0]  x_aligned;
    logic               empty_pkt;
    logic               fire;

    // Last column index of a span rounded up to whole granules.
    assign last_col_w = (width - FIELD_W'(1)) | FIELD_W'(GRAN - 1);
    assign x_aligned  = {x_gran, {GRAN_LOG2{1'b0}}};
    assign empty_pkt  = (width == '0) || (height == '0);
    assign fire       = wk_q.active && mem_ready;

    always_comb begin
        wk_d      = wk_q;
        wk_d.done = 1'b0;
        if (launch) begin
            wk_d.color    = color;
            wk_d.x_base   = x_aligned;
            wk_d.x        = x_aligned;
            wk_d.y        = y_start;
            wk_d.col      = '0;
            wk_d.row      = '0;
            wk_d.last_col = last_col_w;
            wk_d.last_row = height - FIELD_W'(1);
            wk_d.active   = !empty_pkt;
            wk_d.done     = empty_pkt;
        end else if (fire) begin
            if (wk_q.col == wk_q.last_col) begin
                wk_d.col = '0;
                wk_d.x   = wk_q.x_base;
                wk_d.y   = wk_q.y + Y_BITS'(1);
                if (wk_q.row == wk_q.last_row) begin
                    wk_d.active = 1'b0;
                    wk_d.done   = 1'b1;
                end else begin
                    wk_d.row = wk_q.row + FIELD_W'(1);
                end
            end else begin
                wk_d.col = wk_q.col + FIELD_W'(1);
                wk_d.x   = wk_q.x + X_BITS'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign mem_addr  = {wk_q.y, wk_q.x};
    assign mem_wdata = wk_q.color;
    assign mem_we    = wk_q.active;
    assign busy      = wk_q.active;
    assign done      = wk_q.done;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)))
        else $error("write changed during stall"); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done wider than one cycle"); // R12

    AST_DONE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we) else $error("write during done"); // R12

    AST_FIRST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> (mem_addr[GRAN_LOG2-1:0] == '0))
        else $error("first write not on granule"); // R6

endmodule

// File: rtl/vram_fill_engine.sv
module vram_fill_engine
    import fill_pkg::*;
#(
    parameter int X_BITS    = 10,
    parameter int Y_BITS    = 9,
    parameter int GRAN_LOG2 = 4,
    localparam int XG_BITS  = X_BITS - GRAN_LOG2,
    localparam int ADDR_W   = X_BITS + Y_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_data,
    output logic              cmd_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done
);

    logic                 launch;
    logic [PIX_W-1:0]     pkt_color;
    logic [XG_BITS-1:0]   pkt_xg;
    logic [Y_BITS-1:0]    pkt_y;
    logic [FIELD_W-1:0]   pkt_w;
    logic [FIELD_W-1:0]   pkt_h;

    fill_pkt_capture #(
        .X_BITS    (X_BITS),
        .Y_BITS    (Y_BITS),
        .GRAN_LOG2 (GRAN_LOG2)
    ) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .engine_busy (busy),
        .cmd_ready   (cmd_ready),
        .launch      (launch),
        .color_o     (pkt_color),
        .x_gran_o    (pkt_xg),
        .y_o         (pkt_y),
        .width_o     (pkt_w),
        .height_o    (pkt_h)
    );

    fill_addr_walker #(
        .X_BITS    (X_BITS),
        .Y_BITS    (Y_BITS),
        .GRAN_LOG2 (GRAN_LOG2)
    ) i_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .color     (pkt_color),
        .x_gran    (pkt_xg),
        .y_start   (pkt_y),
        .width     (pkt_w),
        .height    (pkt_h),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done)
    );

    AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_wdata[15]) else $error("bit 15 set on write"); // R5

endmodule

// File: tb/test_vram_fill_engine.sv
module test_vram_fill_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready;
    logic [18:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic        mem_ready = 1'b1;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    int done_seen = 0;
    int pkts_sent = 0;
    bit finished = 0;
    bit stall_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [18:0] exp_addr[$];
    logic [15:0] exp_data[$];
    string       exp_tag[$];

    always #4 clk = ~clk;

    vram_fill_engine i_vram_fill_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_ready(mem_ready), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Memory ready: constant high or pseudo-random when stalls are on.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = stall_mode ? lfsr[0] : 1'b1;
        end
    end

    // Monitor: pops the scoreboard on every completed write.
    logic        stall_prev = 1'b0;
    logic [18:0] stall_addr;
    logic [15:0] stall_data;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (stall_prev) begin
                check(mem_we && mem_addr == stall_addr && mem_wdata == stall_data,
                      "R11 stall hold", {mem_we, mem_addr}, {1'b1, stall_addr});
            end
            stall_prev = mem_we && !mem_ready;
            stall_addr = mem_addr;
            stall_data = mem_wdata;
            if (mem_we && mem_ready) begin
                if (exp_addr.size() == 0) begin
                    check(0, "R9 unexpected write", {13'd0, mem_addr}, 32'd0);
                end else begin
                    logic [18:0] ea;
                    logic [15:0] ed;
                    string       et;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    et = exp_tag.pop_front();
                    check(mem_addr == ea, et, {13'd0, mem_addr}, {13'd0, ea});
                    check(mem_wdata == ed, "R4 colour", {16'd0, mem_wdata}, {16'd0, ed});
                    check(!mem_wdata[15], "R5 bit15", {31'd0, mem_wdata[15]}, 32'd0);
                end
            end
            if (done) begin
                done_seen++;
                check(exp_addr.size() == 0, "R12 done before last write",
                      exp_addr.size(), 32'd0);
                check(!mem_we, "R12 write with done", {31'd0, mem_we}, 32'd0);
            end
            if (busy) begin
                check(!cmd_ready, "R12 ready while busy", {31'd0, cmd_ready}, 32'd0);
            end
        end
    end

    // Called just after a posedge; returns just after the posedge that took the word.
    task automatic send_word(input logic [31:0] w);
        cmd_valid = 1'b1;
        cmd_data  = w;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    // Driver: pushes the expected writes, then sends the packet.
    task automatic send_fill(input logic [23:0] c, input logic [15:0] x, input logic [15:0] y,
                             input logic [15:0] w, input logic [15:0] h, input string tag);
        logic [15:0] d;
        int nc;
        int xs;
        d  = {1'b0, c[23:19], c[15:11], c[7:3]};              // R4 packing
        nc = (w == 0) ? 0 : ((int'(w) + 15) / 16) * 16;       // R7 rounding
        xs = int'(x) & 1008;                                  // R6 snap, R10 modulo 1024
        for (int r = 0; r < int'(h); r++) begin
            for (int k = 0; k < nc; k++) begin
                logic [8:0] ya;
                logic [9:0] xa;
                ya = 9'((int'(y) + r) % 512);
                xa = 10'((xs + k) % 1024);
                exp_addr.push_back({ya, xa});
                exp_data.push_back(d);
                exp_tag.push_back(tag);
            end
        end
        pkts_sent++;
        send_word({8'h02, c});
        send_word({y, x});
        send_word({h, w});
        @(negedge clk);
        if (nc == 0 || h == 0) begin
            check(done && !busy, "R8 empty packet done", {30'd0, done, busy}, 32'd2);
        end else begin
            check(busy && !cmd_ready, "R12 busy after packet", {30'd0, busy, cmd_ready}, 32'd2);
        end
        while (!done) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(!busy && !done && !mem_we && cmd_ready, "R1 reset state",
              {28'd0, busy, done, mem_we, cmd_ready}, 32'd1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        send_fill(24'hFF8040, 16'd0, 16'd0, 16'd16, 16'd2, "R2 basic packet");
        send_fill(24'h13579B, 16'd37, 16'd5, 16'd17, 16'd1, "R6 aligned start");
        send_fill(24'hC0FFEE, 16'd64, 16'd10, 16'd1, 16'd3, "R7 width round up");
        send_fill(24'h0A0B0C, 16'd100, 16'd20, 16'd48, 16'd2, "R9 row order");

        // Junk lead word is dropped (R3).
        send_word(32'h05123456);
        @(negedge clk);
        check(!busy && !mem_we && cmd_ready, "R3 junk dropped",
              {29'd0, busy, mem_we, cmd_ready}, 32'd1);
        @(posedge clk);
        #1;
        send_fill(24'h808080, 16'd16, 16'd1, 16'd16, 16'd1, "R3 packet after junk");

        send_fill(24'h112233, 16'd1020, 16'd511, 16'd32, 16'd2, "R10 wrap");
        send_fill(24'hABCDEF, 16'd3000, 16'd700, 16'd16, 16'd1, "R10 field modulo");

        send_fill(24'h445566, 16'd0, 16'd0, 16'd0, 16'd4, "R8 zero width");
        send_fill(24'h445566, 16'd0, 16'd0, 16'd8, 16'd0, "R8 zero height");

        stall_mode = 1;
        send_fill(24'hF0F0F0, 16'd500, 16'd300, 16'd40, 16'd3, "R11 stalled fill");
        send_fill(24'h0F0F0F, 16'd1008, 16'd510, 16'd33, 16'd3, "R11 stalled wrap");
        stall_mode = 0;

        repeat (4) @(negedge clk);
        check(done_seen == pkts_sent, "R12 done count", done_seen, pkts_sent);
        check(exp_addr.size() == 0, "R7 all writes seen", exp_addr.size(), 32'd0);
        summary();
    end

endmodule